// File: doc/BRIEF.md
# Cascadable Dual Timer/Counter

This block holds two 16-bit counting halves, A and B, that software programs through a small register port. Each half counts either every module clock (timer mode), the rising edges of its external input (timer mode with external clock), or qualified events of that input (counter mode: rising, falling or both edges, or the active level). It counts up or down, and it runs once or cyclically. When a half passes its limit, it reloads from its reload register and raises a pending interrupt. The interrupt goes out on the half's `irq` line when it is enabled.

A control bit on half A joins the two halves into one 32-bit counter. In that mode half A's control, run, reload and count registers cover the whole 32-bit value, and only A's interrupt is reported. Counting is started, resumed, stopped or reloaded through a write-only run register per half.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every readable register returns zero and both `irq` bits are low. Both halves are stopped, in 16-bit down-counting timer mode.
- R2: Control bit layout: bit1 = up, bit2 = counter mode, bit3 = one-shot, bit5 = invert, bits 7:6 = edge select, bit8 = input already synchronous, bit9 = external clock in timer mode. In timer mode with bit9 clear, a running down-counter loses one per clock. A counting event taken while the count is zero reloads the count instead, so the period is reload+1 events.
- R3: With bit1 set, the count gains one per event. An event taken at all ones reloads the count.
- R4: Run register bits: bit0 start, bit1 stop, bit2 load count from reload. Start without load resumes from the held count. Stop beats start in the same write. A cycle that carries a run command for a half does not also count that half. A stopped half holds its count.
- R5: In one-shot mode (bit3 = 1) a wrap reloads the count and clears the half's enable status, which reads back as control bit0.
- R6: In counter mode the edge field selects 01 rising, 10 falling, 11 both, applied after optional inversion. Without bit8, an input change is counted two clocks later than with bit8 set, because of a two-flop synchronizer.
- R7: In counter mode with edge field 00, the half counts on every clock where the input is high, or low when bit5 is set.
- R8: In timer mode with bit9 set, the half counts rising edges of the (optionally inverted) external input.
- R9: Control bit4 on A cascades the halves into one 32-bit counter driven by A's settings and A's run register, with the borrow or carry crossing from A to B. The reload and count registers are read and written as 32-bit values at A's addresses. Writes to B's run register are ignored while cascaded.
- R10: A wrap sets the half's pending bit (index 0 = A, 1 = B) on the same edge that reloads the count. `irq` is pending AND enabled. Writing 1 to a bit of the clear register clears that bit. A wrap in the same cycle wins over the clear.
- R11: While cascaded, B's pending bit is never set and `irq[1]` stays low.
- R12: Register addresses: 0 control A, 1 control B, 2 run A, 3 run B, 4 reload A, 5 reload B, 6 count A, 7 count B, 8 interrupt enable, 9 interrupt clear (reads back the pending bits). Control bit0 is read-only. B has no bit4 and reads it as zero. The run registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 2*HALF_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 2*HALF_W | Combinational read data for rd_addr |
| ext_in | input | 2 | External event inputs, bit0 to A, bit1 to B |
| irq | output | 2 | Enabled pending interrupts, bit0 A, bit1 B |

## Verification
Register writes, run commands, count steps, reloads and pending bits all take effect on the clock edge that carries the write or event. The new values are therefore visible on `rd_data` and `irq` in the cycle right after that edge. External input changes reach the count two edges later through the synchronizer, or on the same edge when the synchronous bit is set. The bench models this timing behaviourally with a short sample history. It compares the read data and `irq` against the model at every falling edge, half a cycle after each update. Hand-computed values at the corner points (borrow across halves, stop priority, one-shot end, edge counts) are checked on top of that comparison.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] RG_CTRL_A = 4'd0;
   localparam logic [REG_AW-1:0] RG_CTRL_B = 4'd1;
   localparam logic [REG_AW-1:0] RG_RUN_A  = 4'd2;
   localparam logic [REG_AW-1:0] RG_RUN_B  = 4'd3;
   localparam logic [REG_AW-1:0] RG_RLD_A  = 4'd4;
   localparam logic [REG_AW-1:0] RG_RLD_B  = 4'd5;
   localparam logic [REG_AW-1:0] RG_CNT_A  = 4'd6;
   localparam logic [REG_AW-1:0] RG_CNT_B  = 4'd7;
   localparam logic [REG_AW-1:0] RG_IEN    = 4'd8;
   localparam logic [REG_AW-1:0] RG_ICLR   = 4'd9;

   localparam logic [1:0] EDGE_NONE = 2'b00;
   localparam logic [1:0] EDGE_RISE = 2'b01;
   localparam logic [1:0] EDGE_FALL = 2'b10;
   localparam logic [1:0] EDGE_BOTH = 2'b11;

   // control bits 9:1, MSB first
   typedef struct packed {
      logic       ext_clk;
      logic       sync_in;
      logic [1:0] edge_sel;
      logic       invert;
      logic       cascade;
      logic       one_shot;
      logic       cnt_mode;
      logic       up;
   } tmr_ctrl_t;

   localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_evt_gen.sv
module tmr_evt_gen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_in,
   input  logic       cnt_mode,
   input  logic       ext_clk,
   input  logic       invert,
   input  logic       sync_in,
   input  logic [1:0] edge_sel,
   output logic       evt
);
   import tmr_pkg::*;

   logic raw_s;
   logic sample, lvl, prev_q, rise, fall;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= ext_in;
         end
         assign raw_s = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], ext_in};
         end
         assign raw_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   assign sample = sync_in ? ext_in : raw_s;
   assign lvl    = sample ^ invert;
   assign rise   = lvl & ~prev_q;
   assign fall   = ~lvl & prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   always_comb begin
      if (!cnt_mode) begin
         evt = ext_clk ? rise : 1'b1;
      end else begin
         case (edge_sel)
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            EDGE_BOTH: evt = rise | fall;
            default:   evt = lvl;
         endcase
      end
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int HALF_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cascade,
   input  logic [1:0]             up,
   input  logic [1:0]             once,
   input  logic [1:0]             evt,
   input  logic [1:0]             start,
   input  logic [1:0]             stop,
   input  logic [1:0]             load,
   input  logic [1:0][HALF_W-1:0] rl,
   output logic [1:0][HALF_W-1:0] cnt,
   output logic [1:0]             run,
   output logic [1:0]             wrap
);
   localparam int FULL_W = 2 * HALF_W;

   logic [1:0] cmd, step, at_lim;
   logic       full_lim;
   logic [FULL_W-1:0] full_cnt;

   assign full_cnt = cnt;

   always_comb begin
      for (int h = 0; h < 2; h++) begin
         cmd[h]    = start[h] | stop[h] | load[h];
         at_lim[h] = up[h] ? (&cnt[h]) : (cnt[h] == '0);
      end
      full_lim = up[0] ? (&full_cnt) : (full_cnt == '0);
      step[0]  = run[0] & evt[0] & ~cmd[0];
      step[1]  = ~cascade & run[1] & evt[1] & ~cmd[1];
      wrap[0]  = step[0] & (cascade ? full_lim : at_lim[0]);
      wrap[1]  = step[1] & at_lim[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= '0;
      end else begin
         if (cascade) begin
            if (load[0] || wrap[0]) cnt <= rl;
            else if (step[0])       cnt <= up[0] ? full_cnt + 1'b1 : full_cnt - 1'b1;
         end else begin
            for (int h = 0; h < 2; h++) begin
               if (load[h] || wrap[h]) cnt[h] <= rl[h];
               else if (step[h])       cnt[h] <= up[h] ? cnt[h] + 1'b1 : cnt[h] - 1'b1;
            end
         end
         for (int h = 0; h < 2; h++) begin
            if (h == 1 && cascade)          run[h] <= run[h];
            else if (stop[h])               run[h] <= 1'b0;
            else if (start[h])              run[h] <= 1'b1;
            else if (wrap[h] && once[h])    run[h] <= 1'b0;
         end
      end
   end

   // R2: a wrap of a lone half leaves the reload value in the count
   p_wrap_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap[0] && !cascade) |=> (cnt[0] == $past(rl[0])));

   // R9: a cascaded wrap reloads all 32 bits
   p_casc_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap[0] && cascade) |=> (cnt == $past(rl)));

   // R4: stop always wins
   p_stop_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop[0] |=> !run[0]);

   // R4: a stopped half without load holds its count
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[0] && !load[0]) |=> $stable(cnt[0]));

   // R5: one-shot ends after its wrap
   p_oneshot_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap[0] && once[0]) |=> !run[0]);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] wrap,
   input  logic       cascade,
   input  logic       ien_we,
   input  logic       clr_we,
   input  logic [1:0] wd,
   output logic [1:0] ien,
   output logic [1:0] pend,
   output logic [1:0] irq
);
   logic [1:0] clr_mask;

   assign clr_mask = clr_we ? wd : 2'b00;
   assign irq      = pend & ien & {~cascade, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien  <= '0;
         pend <= '0;
      end else begin
         if (ien_we) ien <= wd;
         pend <= (pend & ~clr_mask) | wrap;
      end
   end

   // R10: a wrap always leaves its pending bit set
   p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[0] |=> pend[0]);

   // R10: clearing without a new wrap takes effect
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wd[0] && !wrap[0]) |=> !pend[0]);

   // R11: B's pending bit cannot rise while cascaded
   p_casc_b_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade && !pend[1]) |=> !pend[1]);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int HALF_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_AW-1:0]     wr_addr,
   input  logic [2*HALF_W-1:0]   wr_data,
   input  logic [REG_AW-1:0]     rd_addr,
   output logic [2*HALF_W-1:0]   rd_data,
   input  logic [1:0]            ext_in,
   output logic [1:0]            irq
);
   localparam int DATA_W = 2 * HALF_W;

   generate
      if (HALF_W < 8) begin : g_bad_width
         $error("tmr_pair: HALF_W must be at least 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("tmr_pair: SYNC_STAGES must be at least 1");
      end
   endgenerate

   tmr_ctrl_t                ctrl_q [2];
   tmr_ctrl_t                wr_ctrl, wr_ctrl_b;
   logic [1:0][HALF_W-1:0]   rl_q;
   logic [1:0][HALF_W-1:0]   cnt_w;
   logic [1:0]               run_w, wrap_w, evt_w;
   logic [1:0]               start_p, stop_p, load_p;
   logic [1:0]               ien_w, pend_w;
   logic                     cascade;

   assign cascade = ctrl_q[0].cascade;

   always_comb begin
      wr_ctrl           = tmr_ctrl_t'(wr_data[CTRL_W:1]);
      wr_ctrl_b         = wr_ctrl;
      wr_ctrl_b.cascade = 1'b0;
   end

   // run-register command pulses
   genvar h;
   generate
      for (h = 0; h < 2; h++) begin : g_half
         logic hit;
         assign hit        = wr_en && (wr_addr == RG_RUN_A + REG_AW'(h));
         assign start_p[h] = hit & wr_data[0];
         assign stop_p[h]  = hit & wr_data[1];
         assign load_p[h]  = hit & wr_data[2];

         tmr_evt_gen #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ext_in   (ext_in[h]),
            .cnt_mode (ctrl_q[h].cnt_mode),
            .ext_clk  (ctrl_q[h].ext_clk),
            .invert   (ctrl_q[h].invert),
            .sync_in  (ctrl_q[h].sync_in),
            .edge_sel (ctrl_q[h].edge_sel),
            .evt      (evt_w[h])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q[0] <= '0;
         ctrl_q[1] <= '0;
         rl_q      <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RG_CTRL_A: ctrl_q[0] <= wr_ctrl;
            RG_CTRL_B: ctrl_q[1] <= wr_ctrl_b;
            RG_RLD_A: begin
               rl_q[0] <= wr_data[HALF_W-1:0];
               if (cascade) rl_q[1] <= wr_data[DATA_W-1:HALF_W];
            end
            RG_RLD_B:  rl_q[1] <= wr_data[HALF_W-1:0];
            default: ;
         endcase
      end
   end

   tmr_counter #(.HALF_W(HALF_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cascade (cascade),
      .up      ({ctrl_q[1].up, ctrl_q[0].up}),
      .once    ({ctrl_q[1].one_shot, ctrl_q[0].one_shot}),
      .evt     (evt_w),
      .start   (start_p),
      .stop    (stop_p),
      .load    (load_p),
      .rl      (rl_q),
      .cnt     (cnt_w),
      .run     (run_w),
      .wrap    (wrap_w)
   );

   tmr_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap_w),
      .cascade (cascade),
      .ien_we  (wr_en && wr_addr == RG_IEN),
      .clr_we  (wr_en && wr_addr == RG_ICLR),
      .wd      (wr_data[1:0]),
      .ien     (ien_w),
      .pend    (pend_w),
      .irq     (irq)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         RG_CTRL_A: rd_data = DATA_W'({ctrl_q[0], run_w[0]});
         RG_CTRL_B: rd_data = DATA_W'({ctrl_q[1], run_w[1]});
         RG_RLD_A:  rd_data = cascade ? rl_q : DATA_W'(rl_q[0]);
         RG_RLD_B:  rd_data = DATA_W'(rl_q[1]);
         RG_CNT_A:  rd_data = cascade ? cnt_w : DATA_W'(cnt_w[0]);
         RG_CNT_B:  rd_data = DATA_W'(cnt_w[1]);
         RG_IEN:    rd_data = DATA_W'(ien_w);
         RG_ICLR:   rd_data = DATA_W'(pend_w);
         default:   rd_data = '0;
      endcase
   end

   // R12: control bit4 of half B never reads back as set
   p_b_no_cascade_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[1].cascade);
endmodule

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
   localparam int SS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  ext_in = '0;
   logic [1:0]  irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   string cur_req = "R1";

   tmr_pair #(.HALF_W(16), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ext_in(ext_in), .irq(irq)
   );

   always #5 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int     m_ctrl [2];
   int     m_run  [2];
   longint m_cnt  [2];
   longint m_rl   [2];
   int     m_ien, m_pend;
   int     m_prev [2];
   int     past   [2][4];

   function automatic longint model_rd(int a);
      int casc = (m_ctrl[0] >> 4) & 1;
      case (a)
         0: return longint'((m_ctrl[0] & 'h3FE) | m_run[0]);
         1: return longint'((m_ctrl[1] & 'h3EE) | m_run[1]);
         4: return casc ? (m_rl[1] << 16) | m_rl[0] : m_rl[0];
         5: return m_rl[1];
         6: return casc ? (m_cnt[1] << 16) | m_cnt[0] : m_cnt[0];
         7: return m_cnt[1];
         8: return longint'(m_ien);
         9: return longint'(m_pend);
         default: return 0;
      endcase
   endfunction

   function automatic int model_irq();
      int casc = (m_ctrl[0] >> 4) & 1;
      return m_pend & m_ien & (casc ? 1 : 3);
   endfunction

   task automatic model_edge();
      int evt [2];
      int lvl [2];
      int st [2], sp [2], ld [2];
      int wrapv [2];
      int casc;
      for (int k = 0; k < 2; k++) begin
         int c = m_ctrl[k];
         int samp = ((c >> 8) & 1) ? int'(ext_in[k]) : past[k][SS-1];
         int l = samp ^ ((c >> 5) & 1);
         int r = l & (m_prev[k] == 0);
         int f = (l == 0) & m_prev[k];
         lvl[k] = l;
         if (((c >> 2) & 1) == 0) evt[k] = ((c >> 9) & 1) ? r : 1;
         else case ((c >> 6) & 3)
            1: evt[k] = r;
            2: evt[k] = f;
            3: evt[k] = r | f;
            default: evt[k] = l;
         endcase
         st[k] = (wr_en && wr_addr == 4'(2 + k)) ? int'(wr_data[0]) : 0;
         sp[k] = (wr_en && wr_addr == 4'(2 + k)) ? int'(wr_data[1]) : 0;
         ld[k] = (wr_en && wr_addr == 4'(2 + k)) ? int'(wr_data[2]) : 0;
         wrapv[k] = 0;
      end
      casc = (m_ctrl[0] >> 4) & 1;
      if (casc) begin
         longint full = (m_cnt[1] << 16) | m_cnt[0];
         longint rlf  = (m_rl[1] << 16) | m_rl[0];
         int up = (m_ctrl[0] >> 1) & 1;
         int cmd = st[0] | sp[0] | ld[0];
         if (ld[0]) full = rlf;
         else if (m_run[0] && evt[0] && !cmd) begin
            if ((up && full == 64'hFFFF_FFFF) || (!up && full == 0)) begin
               full = rlf; wrapv[0] = 1;
            end else full = (up ? full + 1 : full - 1) & 64'hFFFF_FFFF;
         end
         m_cnt[0] = full & 'hFFFF;
         m_cnt[1] = (full >> 16) & 'hFFFF;
         if (sp[0]) m_run[0] = 0;
         else if (st[0]) m_run[0] = 1;
         else if (wrapv[0] && ((m_ctrl[0] >> 3) & 1)) m_run[0] = 0;
      end else begin
         for (int k = 0; k < 2; k++) begin
            int up = (m_ctrl[k] >> 1) & 1;
            int cmd = st[k] | sp[k] | ld[k];
            if (ld[k]) m_cnt[k] = m_rl[k];
            else if (m_run[k] && evt[k] && !cmd) begin
               if ((up && m_cnt[k] == 'hFFFF) || (!up && m_cnt[k] == 0)) begin
                  m_cnt[k] = m_rl[k]; wrapv[k] = 1;
               end else m_cnt[k] = (up ? m_cnt[k] + 1 : m_cnt[k] - 1) & 'hFFFF;
            end
            if (sp[k]) m_run[k] = 0;
            else if (st[k]) m_run[k] = 1;
            else if (wrapv[k] && ((m_ctrl[k] >> 3) & 1)) m_run[k] = 0;
         end
      end
      // register writes use the pre-edge cascade setting
      if (wr_en) begin
         case (wr_addr)
            0: m_ctrl[0] = int'(wr_data) & 'h3FE;
            1: m_ctrl[1] = int'(wr_data) & 'h3EE;
            4: begin
               m_rl[0] = wr_data & 'hFFFF;
               if (casc) m_rl[1] = (wr_data >> 16) & 'hFFFF;
            end
            5: m_rl[1] = wr_data & 'hFFFF;
            8: m_ien = int'(wr_data) & 3;
            default: ;
         endcase
      end
      m_pend = (m_pend & ~((wr_en && wr_addr == 9) ? (int'(wr_data) & 3) : 0))
               | wrapv[0] | (wrapv[1] << 1);
      for (int k = 0; k < 2; k++) begin
         m_prev[k] = lvl[k];
         for (int j = 3; j > 0; j--) past[k][j] = past[k][j-1];
         past[k][0] = int'(ext_in[k]);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_ctrl[k] = 0; m_run[k] = 0; m_cnt[k] = 0; m_rl[k] = 0; m_prev[k] = 0;
            for (int j = 0; j < 4; j++) past[k][j] = 0;
         end
         m_ien = 0; m_pend = 0;
      end else model_edge();
   end

   // per-clock comparison, half a cycle after the update
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (longint'(rd_data) != model_rd(int'(rd_addr))) begin
            n_fail++;
            $display("FAIL %s addr %0d: rd_data actual %h expected %h", cur_req,
                     rd_addr, rd_data, model_rd(int'(rd_addr)));
         end
         n_checks++;
         if (int'(irq) != model_irq()) begin
            n_fail++;
            $display("FAIL %s irq actual %b expected %0d", cur_req, irq, model_irq());
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic check_eq(string req, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, longint d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_rd(int a, longint exp, string req);
      rd_addr = 4'(a);
      @(negedge clk);
      check_eq(req, longint'(rd_data), exp);
   endtask

   task automatic pulse_ext(int k, int times);
      for (int i = 0; i < times; i++) begin
         ext_in[k] = 1'b1; idle(3);
         ext_in[k] = 1'b0; idle(3);
      end
   endtask

   initial begin
      longint held;
      idle(3);
      rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      for (int a = 0; a < 10; a++) expect_rd(a, 0, "R1");
      check_eq("R1", longint'(irq), 0);

      // R2: internal down timer, period reload+1
      cur_req = "R2";
      rd_addr = 6;
      wr(4, 5);
      wr(8, 1);
      wr(2, 5);
      expect_rd(6, 5, "R2");
      idle(14);
      expect_rd(9, 1, "R10");
      check_eq("R10", longint'(irq), 1);

      // R10: clear and mask
      cur_req = "R10";
      wr(9, 1);
      idle(3);
      wr(8, 0);
      idle(8);

      // R4: stop, resume, stop-wins, load only
      cur_req = "R4";
      wr(2, 2);
      rd_addr = 6;
      @(negedge clk); held = longint'(rd_data);
      idle(5);
      expect_rd(6, held, "R4");
      wr(2, 1);
      idle(3);
      wr(2, 3);
      expect_rd(0, 0, "R4");
      wr(4, 9);
      wr(2, 4);
      expect_rd(6, 9, "R4");

      // R3: up counting wrap at all ones
      cur_req = "R3";
      rd_addr = 6;
      wr(0, 2);
      wr(4, 'hFFFA);
      wr(8, 1);
      wr(2, 5);
      idle(12);

      // R5: one-shot
      cur_req = "R5";
      wr(2, 2);
      wr(0, 8);
      wr(4, 3);
      wr(2, 5);
      idle(10);
      expect_rd(0, 'h008, "R5");
      expect_rd(6, 3, "R5");

      // R6: edge qualification on half B
      cur_req = "R6";
      rd_addr = 7;
      wr(1, 'h44);
      wr(5, 16);
      wr(8, 3);
      wr(3, 5);
      pulse_ext(1, 6);
      idle(4);
      expect_rd(7, 10, "R6");
      wr(1, 'h84);
      pulse_ext(1, 6);
      idle(4);
      expect_rd(7, 4, "R6");
      wr(1, 'h1C4);
      pulse_ext(1, 3);
      idle(4);
      expect_rd(7, 15, "R6");
      rd_addr = 7;
      wr(1, 'h64);
      pulse_ext(1, 3);
      idle(4);

      // R7: level mode
      cur_req = "R7";
      wr(3, 2);
      wr(5, 100);
      wr(1, 'h04);
      wr(3, 5);
      ext_in[1] = 1'b1; idle(5);
      ext_in[1] = 1'b0; idle(6);
      expect_rd(7, 95, "R7");
      rd_addr = 7;
      wr(1, 'h24);
      idle(6);
      wr(3, 2);

      // R8: timer with external clock
      cur_req = "R8";
      rd_addr = 6;
      wr(2, 2);
      wr(0, 'h200);
      wr(4, 50);
      wr(2, 5);
      pulse_ext(0, 4);
      idle(4);
      expect_rd(6, 46, "R8");

      // R9: cascade borrow, 32-bit access, B run ignored
      cur_req = "R9";
      rd_addr = 6;
      wr(2, 2);
      wr(0, 'h10);
      wr(4, 'h0001_0002);
      wr(2, 5);
      idle(3);
      wr(2, 2);
      expect_rd(6, 'hFFFE, "R9");
      expect_rd(7, 0, "R9");
      expect_rd(4, 'h0001_0002, "R9");
      wr(3, 5);
      idle(3);
      expect_rd(6, 'hFFFE, "R9");

      // R11: cascaded wrap, only A interrupts
      cur_req = "R11";
      rd_addr = 6;
      wr(0, 'h12);
      wr(4, 'hFFFF_FFFC);
      wr(8, 3);
      wr(9, 3);
      wr(2, 5);
      idle(8);
      expect_rd(9, 1, "R11");
      check_eq("R11", longint'(irq), 1);

      // R12: map, read-only bit0, no bit4 on B
      cur_req = "R12";
      wr(2, 2);
      wr(0, 0);
      wr(3, 2);
      wr(1, 'h3FF);
      expect_rd(1, 'h3EE, "R12");
      wr(0, 1);
      expect_rd(0, 0, "R12");
      expect_rd(2, 0, "R12");
      expect_rd(3, 0, "R12");

      idle(2);
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule